// File: doc/BRIEF.md
# Serial In-System Programming Target

This block lets an external host program a device's on-chip memories over a four-wire serial link while the device is held in reset. The host drives a serial clock and a data line. The block receives fixed 32-bit instructions, most significant bit first, and answers on a return data line. It turns the instructions into single-cycle strobes on a simple memory-side port. That port carries a read strobe, a write strobe, a whole-chip erase strobe, a memory select, an address and write data. The memories sit outside the block. The block covers a program memory of parameterised address width and a 64-byte data memory.

The serial link is oversampled in the system clock domain. Data is taken on the rising serial-clock edge, and the return line changes only after a falling edge. Nothing is executed until the host sends the programming-enable instruction. In the third byte of every instruction the block echoes the second byte it received, so the host can confirm frame alignment before and after enabling.

After every write or erase, a busy flag stays set for a parameterised number of clock cycles. Instructions that finish while the flag is set are dropped. Releasing the target reset clears the enable, the bit count and the return line.

Top module: `isp_prog_slave`

## Requirements
- R1: After the block reset, `miso` is 0, `busy` is 0, and none of `mem_rd`, `mem_wr`, `mem_erase` is asserted.
- R2: `mosi` is sampled on rising `sck`. `miso` changes only after a falling `sck` edge, or when the target reset is released. It is held constant while `sck` is high.
- R3: During the third byte of every frame, `miso` returns the second received byte, MSB first, whether or not programming is enabled. The first two bytes return 0x00.
- R4: Until the frame 0xAC, 0x53, any, any has been received, every frame is ignored: no memory strobe is issued and the fourth byte returns 0x00.
- R5: While `tgt_reset_n` is high, the enable, the bit counter and `miso` are held cleared. After `tgt_reset_n` is driven low again, frames realign to a fresh 32-bit boundary and the block must be re-enabled.
- R6: The frame 0xAC, 0x80, any, any issues one `mem_erase` pulse, which clears both memories to 0xFF. `busy` is then high for ERASE_WAIT cycles, counted from the pulse.
- R7: The frame 0x40, hi, lo, d issues one `mem_wr` with `mem_space`=0, `mem_addr`={hi,lo} truncated to PROG_AW bits and `mem_wdata`=d. `busy` is then high for WRITE_WAIT cycles.
- R8: The frame 0xC0, any, a, d writes data-memory location a[5:0] (`mem_space`=1). It does this as two `mem_wr` pulses in consecutive cycles: first 0xFF (erase), then d.
- R9: The frames 0x20, hi, lo, any (program memory) and 0xA0, any, a, any (data memory) issue one `mem_rd` after the third byte and return `mem_rdata` MSB first in the fourth byte.
- R10: A frame that completes, or a read that is decoded, while `busy` is high is ignored: no strobe, and 0x00 in the fourth byte.
- R11: Memory strobes are mutually exclusive. Each read and erase strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial link |
| arst_n | input | 1 | Asynchronous block reset, active low |
| tgt_reset_n | input | 1 | Target reset line; programming is possible only while low |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| mem_rd | output | 1 | One-cycle memory read strobe |
| mem_wr | output | 1 | One-cycle memory write strobe |
| mem_erase | output | 1 | One-cycle whole-chip erase strobe |
| mem_space | output | 1 | 0 selects program memory, 1 selects data memory |
| mem_addr | output | PROG_AW | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the cycle `mem_rd` is high |
| busy | output | 1 | Write or erase in progress; new instructions are dropped |

## Verification
A misaligned bit counter shows up on the third byte of the very next frame: the echo comes back shifted or wrong, within 32 serial clocks. A wrong enable state shows up at the end of the next frame in one of two ways. Either a strobe appears that should not, or an expected write is missing and is later exposed when reading back the programmed value. A miscounted busy window shows up at the first `busy` falling edge as a wrong length. It also shows up when a write that follows an erase is wrongly accepted, which leaves a non-0xFF value in memory.

// File: rtl/isp_prog_pkg.sv
package isp_prog_pkg;
   localparam int BYTE_W      = 8;
   localparam int FRAME_BYTES = 4;
   localparam int FRAME_BITS  = BYTE_W * FRAME_BYTES;
   localparam int BITCNT_W    = $clog2(FRAME_BITS);
   localparam int DATA_AW     = 6;

   localparam logic [7:0] OP_ENA_HI  = 8'hAC;
   localparam logic [7:0] OP_ENA_LO  = 8'h53;
   localparam logic [7:0] OP_ERASE   = 8'h80;
   localparam logic [7:0] OP_RD_PROG = 8'h20;
   localparam logic [7:0] OP_WR_PROG = 8'h40;
   localparam logic [7:0] OP_RD_DATA = 8'hA0;
   localparam logic [7:0] OP_WR_DATA = 8'hC0;
   localparam logic [7:0] BLANK_BYTE = 8'hFF;

   typedef enum logic [2:0] {
      FEV_NONE,
      FEV_BYTE1,
      FEV_BYTE2,
      FEV_BYTE3,
      FEV_FRAME
   } frame_ev_e;
endpackage

// File: rtl/isp_sync_edge.sv
module isp_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic sck_i,
   input  logic mosi_i,
   output logic sck_rise,
   output logic sck_fall,
   output logic mosi_s
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("isp_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sck_q;
   logic [STAGES-1:0] mosi_q;
   logic              sck_prev;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge arst_n) begin
               if (!arst_n) begin
                  sck_q[gi]  <= 1'b0;
                  mosi_q[gi] <= 1'b0;
               end else begin
                  sck_q[gi]  <= sck_i;
                  mosi_q[gi] <= mosi_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge arst_n) begin
               if (!arst_n) begin
                  sck_q[gi]  <= 1'b0;
                  mosi_q[gi] <= 1'b0;
               end else begin
                  sck_q[gi]  <= sck_q[gi-1];
                  mosi_q[gi] <= mosi_q[gi-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) sck_prev <= 1'b0;
      else         sck_prev <= sck_q[STAGES-1];
   end

   assign sck_rise = sck_q[STAGES-1] & ~sck_prev;
   assign sck_fall = ~sck_q[STAGES-1] & sck_prev;
   assign mosi_s   = mosi_q[STAGES-1];
endmodule

// File: rtl/isp_frame_shift.sv
module isp_frame_shift
   import isp_prog_pkg::*;
(
   input  logic                  clk,
   input  logic                  arst_n,
   input  logic                  clr,
   input  logic                  rise,
   input  logic                  fall,
   input  logic                  mosi_s,
   input  logic                  tx_load,
   input  logic [BYTE_W-1:0]     tx_byte,
   output logic [FRAME_BITS-1:0] rx_word,
   output frame_ev_e             ev,
   output logic                  miso
);
   logic [BITCNT_W-1:0] bit_cnt;
   logic [BYTE_W-1:0]   tx_sh;
   frame_ev_e           ev_next;

   always_comb begin
      ev_next = FEV_NONE;
      if (rise && (bit_cnt[2:0] == 3'd7)) begin
         case (bit_cnt[BITCNT_W-1:3])
            2'd0:    ev_next = FEV_BYTE1;
            2'd1:    ev_next = FEV_BYTE2;
            2'd2:    ev_next = FEV_BYTE3;
            default: ev_next = FEV_FRAME;
         endcase
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         bit_cnt <= '0;
         rx_word <= '0;
         ev      <= FEV_NONE;
         tx_sh   <= '0;
         miso    <= 1'b0;
      end else if (clr) begin
         bit_cnt <= '0;
         rx_word <= '0;
         ev      <= FEV_NONE;
         tx_sh   <= '0;
         miso    <= 1'b0;
      end else begin
         ev <= ev_next;
         if (rise) begin
            rx_word <= {rx_word[FRAME_BITS-2:0], mosi_s};
            bit_cnt <= bit_cnt + 1'b1;
         end
         if (fall) miso <= tx_sh[BYTE_W-1];
         if (tx_load)   tx_sh <= tx_byte;
         else if (fall) tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
   end
endmodule

// File: rtl/isp_cmd_ctrl.sv
module isp_cmd_ctrl
   import isp_prog_pkg::*;
#(
   parameter int PROG_AW    = 10,
   parameter int WRITE_WAIT = 40,
   parameter int ERASE_WAIT = 1200
) (
   input  logic                  clk,
   input  logic                  arst_n,
   input  logic                  clr,
   input  frame_ev_e             ev,
   input  logic [FRAME_BITS-1:0] rx_word,
   input  logic [BYTE_W-1:0]     mem_rdata,
   output logic                  tx_load,
   output logic [BYTE_W-1:0]     tx_byte,
   output logic                  mem_rd,
   output logic                  mem_wr,
   output logic                  mem_erase,
   output logic                  mem_space,
   output logic [PROG_AW-1:0]    mem_addr,
   output logic [BYTE_W-1:0]     mem_wdata,
   output logic                  busy,
   output logic                  enabled
);
   localparam int WAIT_MAX = (ERASE_WAIT > WRITE_WAIT) ? ERASE_WAIT : WRITE_WAIT;
   localparam int CNT_W    = $clog2(WAIT_MAX + 1);

   generate
      if (PROG_AW < DATA_AW || PROG_AW > 16) begin : g_bad_aw
         $error("isp_cmd_ctrl: PROG_AW must lie in 6..16");
      end
      if (WRITE_WAIT < 2 || ERASE_WAIT < 1) begin : g_bad_wait
         $error("isp_cmd_ctrl: WRITE_WAIT >= 2 and ERASE_WAIT >= 1 required");
      end
   endgenerate

   logic [CNT_W-1:0]  wait_cnt;
   logic              wr2_pend;
   logic [BYTE_W-1:0] wr2_data;

   // fields of a full frame
   logic [7:0]  f_op, f_b2, f_b3, f_b4;
   // fields after three bytes
   logic [7:0]  p_op, p_b2, p_b3;
   logic [15:0] f_paddr, f_daddr, p_paddr, p_daddr;
   logic        rd_hit;

   assign {f_op, f_b2, f_b3, f_b4} = rx_word;
   assign p_op    = rx_word[23:16];
   assign p_b2    = rx_word[15:8];
   assign p_b3    = rx_word[7:0];
   assign f_paddr = {f_b2, f_b3};
   assign f_daddr = {10'd0, f_b3[DATA_AW-1:0]};
   assign p_paddr = {p_b2, p_b3};
   assign p_daddr = {10'd0, p_b3[DATA_AW-1:0]};
   assign busy    = (wait_cnt != '0);
   assign rd_hit  = enabled && !busy && ((p_op == OP_RD_PROG) || (p_op == OP_RD_DATA));

   always_comb begin
      tx_load = 1'b0;
      tx_byte = '0;
      case (ev)
         FEV_BYTE1, FEV_BYTE3, FEV_FRAME: tx_load = 1'b1;
         FEV_BYTE2: begin
            tx_load = 1'b1;
            tx_byte = rx_word[7:0];
         end
         default: ;
      endcase
      if (mem_rd) begin
         tx_load = 1'b1;
         tx_byte = mem_rdata;
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         enabled   <= 1'b0;
         wait_cnt  <= '0;
         wr2_pend  <= 1'b0;
         wr2_data  <= '0;
         mem_rd    <= 1'b0;
         mem_wr    <= 1'b0;
         mem_erase <= 1'b0;
         mem_space <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else if (clr) begin
         enabled   <= 1'b0;
         wait_cnt  <= '0;
         wr2_pend  <= 1'b0;
         wr2_data  <= '0;
         mem_rd    <= 1'b0;
         mem_wr    <= 1'b0;
         mem_erase <= 1'b0;
         mem_space <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         mem_rd    <= 1'b0;
         mem_wr    <= 1'b0;
         mem_erase <= 1'b0;
         if (wait_cnt != '0) wait_cnt <= wait_cnt - 1'b1;

         if (wr2_pend) begin
            wr2_pend  <= 1'b0;
            mem_wr    <= 1'b1;
            mem_wdata <= wr2_data;
         end

         if (ev == FEV_BYTE3 && rd_hit) begin
            mem_rd    <= 1'b1;
            mem_space <= (p_op == OP_RD_DATA);
            mem_addr  <= (p_op == OP_RD_DATA) ? p_daddr[PROG_AW-1:0]
                                              : p_paddr[PROG_AW-1:0];
         end

         if (ev == FEV_FRAME) begin
            if (!enabled) begin
               if (f_op == OP_ENA_HI && f_b2 == OP_ENA_LO) enabled <= 1'b1;
            end else if (!busy) begin
               case (f_op)
                  OP_ENA_HI: begin
                     if (f_b2 == OP_ERASE) begin
                        mem_erase <= 1'b1;
                        wait_cnt  <= CNT_W'(ERASE_WAIT);
                     end
                  end
                  OP_WR_PROG: begin
                     mem_wr    <= 1'b1;
                     mem_space <= 1'b0;
                     mem_addr  <= f_paddr[PROG_AW-1:0];
                     mem_wdata <= f_b4;
                     wait_cnt  <= CNT_W'(WRITE_WAIT);
                  end
                  OP_WR_DATA: begin
                     mem_wr    <= 1'b1;
                     mem_space <= 1'b1;
                     mem_addr  <= f_daddr[PROG_AW-1:0];
                     mem_wdata <= BLANK_BYTE;
                     wr2_pend  <= 1'b1;
                     wr2_data  <= f_b4;
                     wait_cnt  <= CNT_W'(WRITE_WAIT);
                  end
                  default: ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/isp_prog_slave.sv
module isp_prog_slave
   import isp_prog_pkg::*;
#(
   parameter int PROG_AW     = 10,
   parameter int WRITE_WAIT  = 40,
   parameter int ERASE_WAIT  = 1200,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               arst_n,
   input  logic               tgt_reset_n,
   input  logic               sck,
   input  logic               mosi,
   output logic               miso,
   output logic               mem_rd,
   output logic               mem_wr,
   output logic               mem_erase,
   output logic               mem_space,
   output logic [PROG_AW-1:0] mem_addr,
   output logic [7:0]         mem_wdata,
   input  logic [7:0]         mem_rdata,
   output logic               busy
);
   logic                  sck_rise, sck_fall, mosi_s;
   logic                  clr;
   logic [FRAME_BITS-1:0] rx_word;
   frame_ev_e             ev;
   logic                  tx_load;
   logic [BYTE_W-1:0]     tx_byte;
   logic                  enabled;

   assign clr = tgt_reset_n;

   isp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .arst_n   (arst_n),
      .sck_i    (sck),
      .mosi_i   (mosi),
      .sck_rise (sck_rise),
      .sck_fall (sck_fall),
      .mosi_s   (mosi_s)
   );

   isp_frame_shift u_shift (
      .clk     (clk),
      .arst_n  (arst_n),
      .clr     (clr),
      .rise    (sck_rise),
      .fall    (sck_fall),
      .mosi_s  (mosi_s),
      .tx_load (tx_load),
      .tx_byte (tx_byte),
      .rx_word (rx_word),
      .ev      (ev),
      .miso    (miso)
   );

   isp_cmd_ctrl #(
      .PROG_AW    (PROG_AW),
      .WRITE_WAIT (WRITE_WAIT),
      .ERASE_WAIT (ERASE_WAIT)
   ) u_ctrl (
      .clk       (clk),
      .arst_n    (arst_n),
      .clr       (clr),
      .ev        (ev),
      .rx_word   (rx_word),
      .mem_rdata (mem_rdata),
      .tx_load   (tx_load),
      .tx_byte   (tx_byte),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_erase (mem_erase),
      .mem_space (mem_space),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .busy      (busy),
      .enabled   (enabled)
   );
endmodule

// File: rtl/isp_prog_slave_chk.sv
module isp_prog_slave_chk (
   input logic       clk,
   input logic       arst_n,
   input logic       tgt_reset_n,
   input logic       sck_fall,
   input logic       enabled,
   input logic       miso,
   input logic       mem_rd,
   input logic       mem_wr,
   input logic       mem_erase,
   input logic       mem_space,
   input logic [7:0] mem_wdata,
   input logic       busy
);
   // R2: the return line moves only after a falling serial edge or a target-reset release
   a_r2_miso_on_fall: assert property (@(posedge clk) disable iff (!arst_n)
      !$stable(miso) |-> ($past(sck_fall) || $past(tgt_reset_n)));

   // R4: no memory strobe before programming is enabled
   a_r4_locked_quiet: assert property (@(posedge clk) disable iff (!arst_n)
      !$past(enabled) |-> !(mem_rd || mem_wr || mem_erase) || $past(mem_wr));

   // R5: releasing the target reset drops the enable and silences the port
   a_r5_release_clears: assert property (@(posedge clk) disable iff (!arst_n)
      tgt_reset_n |=> !enabled && !mem_rd && !mem_wr && !mem_erase);

   // R6: the erase strobe starts a fresh busy window and lasts one cycle
   a_r6_erase_starts_busy: assert property (@(posedge clk) disable iff (!arst_n)
      mem_erase |-> busy && !$past(busy));
   a_r6_erase_single: assert property (@(posedge clk) disable iff (!arst_n)
      mem_erase |=> !mem_erase);

   // R8: a data-memory write opens with an erase byte and is followed by the real write
   a_r8_blank_first: assert property (@(posedge clk) disable iff (!arst_n)
      (mem_wr && mem_space && !$past(mem_wr)) |-> (mem_wdata == 8'hFF));
   a_r8_second_write: assert property (@(posedge clk) disable iff (!arst_n)
      (mem_wr && mem_space && !$past(mem_wr)) |=> (mem_wr && mem_space));

   // R10: no new operation is started while busy
   a_r10_read_not_busy: assert property (@(posedge clk) disable iff (!arst_n)
      mem_rd |-> !$past(busy));
   a_r10_write_not_busy: assert property (@(posedge clk) disable iff (!arst_n)
      (mem_wr && !$past(mem_wr)) |-> !$past(busy));

   // R11: strobes are exclusive and reads are single pulses
   a_r11_exclusive: assert property (@(posedge clk) disable iff (!arst_n)
      $onehot0({mem_rd, mem_wr, mem_erase}));
   a_r11_read_single: assert property (@(posedge clk) disable iff (!arst_n)
      mem_rd |=> !mem_rd);
endmodule

bind isp_prog_slave isp_prog_slave_chk u_chk (
   .clk         (clk),
   .arst_n      (arst_n),
   .tgt_reset_n (tgt_reset_n),
   .sck_fall    (sck_fall),
   .enabled     (enabled),
   .miso        (miso),
   .mem_rd      (mem_rd),
   .mem_wr      (mem_wr),
   .mem_erase   (mem_erase),
   .mem_space   (mem_space),
   .mem_wdata   (mem_wdata),
   .busy        (busy)
);

// File: tb/isp_prog_slave_tb.sv
module isp_prog_slave_tb;
   localparam int PROG_AW    = 10;
   localparam int WRITE_WAIT = 40;
   localparam int ERASE_WAIT = 1200;
   localparam int HALF       = 8;

   logic clk = 1'b0;
   logic arst_n = 1'b0;
   logic tgt_reset_n = 1'b0;
   logic sck = 1'b0;
   logic mosi = 1'b0;
   logic miso, mem_rd, mem_wr, mem_erase, mem_space, busy;
   logic [PROG_AW-1:0] mem_addr;
   logic [7:0] mem_wdata, mem_rdata;

   always #2 clk = ~clk;

   isp_prog_slave #(
      .PROG_AW(PROG_AW), .WRITE_WAIT(WRITE_WAIT), .ERASE_WAIT(ERASE_WAIT)
   ) u_dut (
      .clk(clk), .arst_n(arst_n), .tgt_reset_n(tgt_reset_n),
      .sck(sck), .mosi(mosi), .miso(miso),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_erase(mem_erase),
      .mem_space(mem_space), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .busy(busy)
   );

   // memory models
   logic [7:0] prog_mem [0:(1<<PROG_AW)-1];
   logic [7:0] data_mem [0:63];
   initial begin
      for (int i = 0; i < (1<<PROG_AW); i++) prog_mem[i] = 8'h00;
      for (int i = 0; i < 64; i++) data_mem[i] = 8'h00;
   end
   assign mem_rdata = mem_space ? data_mem[mem_addr[5:0]] : prog_mem[mem_addr];
   always @(posedge clk) begin
      if (mem_erase) begin
         for (int i = 0; i < (1<<PROG_AW); i++) prog_mem[i] <= 8'hFF;
         for (int i = 0; i < 64; i++) data_mem[i] <= 8'hFF;
      end else if (mem_wr) begin
         if (mem_space) data_mem[mem_addr[5:0]] <= mem_wdata;
         else           prog_mem[mem_addr] <= mem_wdata;
      end
   end

   int n_chk = 0;
   int n_err = 0;
   int n_str = 0;
   int busy_run = 0;
   int busy_last = 0;
   int unstable = 0;
   bit done = 1'b0;

   // scoreboard of expected strobes: {kind, space, addr, data}; kind 1 rd, 2 wr, 3 erase
   logic [20:0] exp_q[$];

   function automatic logic [20:0] ev_pack(input logic [1:0] k, input logic s,
                                           input logic [9:0] a, input logic [7:0] d);
      return {k, s, a, d};
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   // monitor: pop and compare on every strobe
   always @(negedge clk) begin
      if (arst_n) begin
         if (busy) busy_run++;
         else begin
            if (busy_run != 0) busy_last = busy_run;
            busy_run = 0;
         end
         if (mem_rd || mem_wr || mem_erase) begin
            logic [20:0] got;
            n_str++;
            if (mem_erase)   got = ev_pack(2'd3, 1'b0, 10'd0, 8'd0);
            else if (mem_wr) got = ev_pack(2'd2, mem_space, mem_addr, mem_wdata);
            else             got = ev_pack(2'd1, mem_space, mem_addr, 8'd0);
            n_chk++;
            if (exp_q.size() == 0) begin
               n_err++;
               $display("FAIL R4/R10 unexpected strobe got %h exp none", got);
            end else begin
               logic [20:0] e;
               e = exp_q.pop_front();
               if (got !== e) begin
                  n_err++;
                  $display("FAIL R6-R9 strobe mismatch got %h exp %h", got, e);
               end
            end
         end
      end
   end

   task automatic xfer(input logic [31:0] w, input int nbits, output logic [31:0] rx);
      rx = '0;
      for (int i = 31; i > 31 - nbits; i--) begin
         mosi = w[i];
         repeat (HALF) @(negedge clk);
         sck = 1'b1;
         rx[i] = miso;
         repeat (HALF) @(negedge clk);
         if (miso !== rx[i]) unstable++;
         sck = 1'b0;
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic frame(input logic [7:0] a, b, c, d, input logic [7:0] exp4, input string tag);
      logic [31:0] rx;
      unstable = 0;
      xfer({a, b, c, d}, 32, rx);
      chk({"R3 first bytes zero ", tag}, {16'd0, rx[31:16]}, 32'd0);
      chk({"R3 echo ", tag}, {24'd0, rx[15:8]}, {24'd0, b});
      chk({"R9/R10 byte4 ", tag}, {24'd0, rx[7:0]}, {24'd0, exp4});
      chk({"R2 miso held high ", tag}, unstable, 0);
   endtask

   initial begin
      int s0;
      logic [31:0] junk;
      repeat (5) @(negedge clk);
      arst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 miso", {31'd0, miso}, 32'd0);
      chk("R1 busy", {31'd0, busy}, 32'd0);
      chk("R1 strobes", n_str, 0);

      // R4: locked, write and read ignored
      frame(8'h40, 8'h01, 8'h23, 8'h5A, 8'h00, "R4 locked write");
      frame(8'h20, 8'h01, 8'h23, 8'h00, 8'h00, "R4 locked read");
      chk("R4 no strobes while locked", n_str, 0);

      // enable
      frame(8'hAC, 8'h53, 8'h00, 8'h00, 8'h00, "enable");

      // R7 program write and R9 read back
      exp_q.push_back(ev_pack(2'd2, 1'b0, 10'h123, 8'h5A));
      frame(8'h40, 8'h01, 8'h23, 8'h5A, 8'h00, "R7 prog write");
      exp_q.push_back(ev_pack(2'd1, 1'b0, 10'h123, 8'h00));
      frame(8'h20, 8'h01, 8'h23, 8'h00, 8'h5A, "R9 prog read");
      chk("R7 busy length", busy_last, WRITE_WAIT);

      // R7 address truncation to PROG_AW bits
      exp_q.push_back(ev_pack(2'd2, 1'b0, 10'h007, 8'hA5));
      frame(8'h40, 8'hFC, 8'h07, 8'hA5, 8'h00, "R7 addr trunc");
      exp_q.push_back(ev_pack(2'd1, 1'b0, 10'h007, 8'h00));
      frame(8'h20, 8'h00, 8'h07, 8'h00, 8'hA5, "R9 trunc read");

      // R8 data write as erase then write
      exp_q.push_back(ev_pack(2'd2, 1'b1, 10'h005, 8'hFF));
      exp_q.push_back(ev_pack(2'd2, 1'b1, 10'h005, 8'h3C));
      frame(8'hC0, 8'h00, 8'hC5, 8'h3C, 8'h00, "R8 data write");
      exp_q.push_back(ev_pack(2'd1, 1'b1, 10'h005, 8'h00));
      frame(8'hA0, 8'h00, 8'h05, 8'h00, 8'h3C, "R9 data read");

      // R6 chip erase, R10 write while busy dropped
      exp_q.push_back(ev_pack(2'd3, 1'b0, 10'd0, 8'd0));
      frame(8'hAC, 8'h80, 8'h00, 8'h00, 8'h00, "R6 erase");
      s0 = n_str;
      frame(8'h40, 8'h00, 8'h10, 8'h77, 8'h00, "R10 write while busy");
      chk("R10 busy still high", {31'd0, busy}, 32'd1);
      chk("R10 no strobe while busy", n_str, s0);
      while (busy) @(negedge clk);
      @(negedge clk);
      chk("R6 erase busy length", busy_last, ERASE_WAIT);
      exp_q.push_back(ev_pack(2'd1, 1'b0, 10'h123, 8'h00));
      frame(8'h20, 8'h01, 8'h23, 8'h00, 8'hFF, "R6 prog blank");
      exp_q.push_back(ev_pack(2'd1, 1'b1, 10'h005, 8'h00));
      frame(8'hA0, 8'h00, 8'h05, 8'h00, 8'hFF, "R6 data blank");

      // R5: partial frame, release target reset, realign
      xfer(32'hFFF0_0000, 12, junk);
      tgt_reset_n = 1'b1;
      repeat (10) @(negedge clk);
      chk("R5 miso cleared", {31'd0, miso}, 32'd0);
      tgt_reset_n = 1'b0;
      repeat (4) @(negedge clk);
      s0 = n_str;
      frame(8'h40, 8'h00, 8'h10, 8'h77, 8'h00, "R5 relocked write");
      chk("R5 enable dropped", n_str, s0);
      frame(8'hAC, 8'h53, 8'h00, 8'h00, 8'h00, "R5 re-enable");
      exp_q.push_back(ev_pack(2'd1, 1'b0, 10'h010, 8'h00));
      frame(8'h20, 8'h00, 8'h10, 8'h00, 8'hFF, "R5 realigned read");

      repeat (20) @(negedge clk);
      chk("R11 all expected strobes seen", exp_q.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired got hang exp completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule